// File: doc/BRIEF.md
# Packed Byte SIMD ALU

This block treats a 32-bit word as four independent unsigned 8-bit lanes and performs one lane-parallel operation per clock. Two operands and a 3-bit opcode are sampled on each rising edge; the 32-bit result is registered and appears on the output after that edge. The available operations are wrapping add, wrapping subtract, halving add, saturating add, and a byte select. There is also a sum of absolute differences, which reduces the four lanes to a single scalar.

Alongside the result the block holds a 4-bit flag register with one bit per lane. Add and subtract update this register. The select operation reads it, taking each byte from operand A or operand B according to the flag for that lane. A subtract of (a,b), then a subtract of (b,a), then a select over those two results gives a per-lane absolute difference with no branching. This pattern suits image kernels such as gradient magnitude, thresholding and template matching.

Top module: `bytelane_alu`

## Requirements
- R1: Lane i occupies bits 8i+7:8i, so lane 0 is bits 7:0 and lane 3 is bits 31:24. Opcode 000 (add) returns (a[i]+b[i]) mod 256 in every lane.
- R2: Add sets flag[i] to 1 exactly when lane i carries out of bit 7, and sets it to 0 otherwise.
- R3: Opcode 001 (subtract) returns (a[i]-b[i]) mod 256 in every lane and sets flag[i] to 1 exactly when a[i] >= b[i], unsigned.
- R4: Opcode 010 (halving add) returns (a[i]+b[i])>>1, computed with a 9-bit intermediate, so 0xFF+0xFF gives 0xFF.
- R5: Opcode 011 (saturating add) returns min(a[i]+b[i], 255) in every lane.
- R6: Opcode 100 (select) returns a[i] where flag[i] is 1 and b[i] where it is 0. It uses the flags as left by the last add or subtract sampled at an earlier edge.
- R7: Opcode 101 returns |a[0]-b[0]| + |a[1]-b[1]| + |a[2]-b[2]| + |a[3]-b[3]|, zero-extended to 32 bits. The largest value is 1020.
- R8: Halving add, saturating add, select and sum of absolute differences leave the flag register unchanged.
- R9: Opcodes 110 and 111 return zero and leave the flag register unchanged.
- R10: A synchronous active-high reset clears both the result register and the flag register. While reset is held, both stay at zero.
- R11: Subtract (a,b), then subtract (b,a), then select with A = the second difference and B = the first, issued on consecutive cycles. This returns |a[i]-b[i]| in every lane.
- R12: The result and the flags of an operation sampled at one rising edge appear on the outputs after that edge. A new operation may be issued on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code |
| a_i | input | 32 | Operand A, four byte lanes |
| b_i | input | 32 | Operand B, four byte lanes |
| res_o | output | 32 | Registered result |
| flags_o | output | 4 | Per-lane flag register, bit i for lane i |

## Verification
Every result and every flag update is due exactly one rising edge after the edge that samples the opcode and operands. A select sees the flags written by the operation sampled at the previous edge. The bench drives inputs on the falling edge and samples res_o and flags_o 1 ns after the next rising edge. It compares them there against a lane model that carries its own copy of the flags from one operation to the next. Operations are issued back to back, so the absolute-difference sequence and the flag-hold cases exercise this one-cycle hand-off between the flag register and the select.

// File: rtl/bytelane_pkg.sv
package bytelane_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_HADD = 3'd2,
    OP_QADD = 3'd3,
    OP_SEL  = 3'd4,
    OP_SAD  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } bl_op_e;
endpackage

// File: rtl/bl_lane.sv
module bl_lane
  import bytelane_pkg::*;
#(
  parameter int W = 8
) (
  input  bl_op_e         op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           flag_q,
  output logic [W-1:0]   res,
  output logic [W-1:0]   absd,
  output logic           flag_d
);
  logic [W:0]   sum_x;
  logic [W:0]   dif_x;
  logic [W-1:0] rev_d;
  logic         carry;
  logic         a_ge_b;

  always_comb begin
    sum_x  = {1'b0, a} + {1'b0, b};
    dif_x  = {1'b0, a} - {1'b0, b};
    rev_d  = b - a;
    carry  = sum_x[W];
    a_ge_b = ~dif_x[W];
    absd   = a_ge_b ? dif_x[W-1:0] : rev_d;
  end

  always_comb begin
    res    = '0;
    flag_d = flag_q;
    unique case (op)
      OP_ADD:  begin res = sum_x[W-1:0]; flag_d = carry;  end
      OP_SUB:  begin res = dif_x[W-1:0]; flag_d = a_ge_b; end
      OP_HADD: res = sum_x[W:1];
      OP_QADD: res = carry ? {W{1'b1}} : sum_x[W-1:0];
      OP_SEL:  res = flag_q ? a : b;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/bl_sad_sum.sv
module bl_sad_sum #(
  parameter int LANES = 4,
  parameter int W     = 8,
  parameter int OUT_W = 10
) (
  input  logic [LANES*W-1:0] absd_flat,
  output logic [OUT_W-1:0]   total
);
  always_comb begin
    total = '0;
    for (int i = 0; i < LANES; i++) begin
      total = total + OUT_W'(absd_flat[i*W +: W]);
    end
  end
endmodule

// File: rtl/bytelane_alu.sv
module bytelane_alu
  import bytelane_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [2:0]              op_i,
  input  logic [LANES*LANE_W-1:0] a_i,
  input  logic [LANES*LANE_W-1:0] b_i,
  output logic [LANES*LANE_W-1:0] res_o,
  output logic [LANES-1:0]        flags_o
);
  localparam int WORD_W  = LANES * LANE_W;
  localparam int SAD_MAX = LANES * ((1 << LANE_W) - 1);
  localparam int SAD_W   = $clog2(SAD_MAX + 1);

  bl_op_e             op;
  logic [WORD_W-1:0]  lane_res;
  logic [WORD_W-1:0]  lane_abs;
  logic [LANES-1:0]   flag_nxt;
  logic [SAD_W-1:0]   sad_total;
  logic [WORD_W-1:0]  res_nxt;
  logic [WORD_W-1:0]  res_q;
  logic [LANES-1:0]   flag_q;

  assign op = bl_op_e'(op_i);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bl_lane #(.W(LANE_W)) u_lane (
      .op     (op),
      .a      (a_i[g*LANE_W +: LANE_W]),
      .b      (b_i[g*LANE_W +: LANE_W]),
      .flag_q (flag_q[g]),
      .res    (lane_res[g*LANE_W +: LANE_W]),
      .absd   (lane_abs[g*LANE_W +: LANE_W]),
      .flag_d (flag_nxt[g])
    );
  end

  bl_sad_sum #(.LANES(LANES), .W(LANE_W), .OUT_W(SAD_W)) u_sad (
    .absd_flat (lane_abs),
    .total     (sad_total)
  );

  always_comb begin
    if (op == OP_SAD) res_nxt = WORD_W'(sad_total);
    else              res_nxt = lane_res;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      flag_q <= '0;
    end else begin
      res_q  <= res_nxt;
      flag_q <= flag_nxt;
    end
  end

  assign res_o   = res_q;
  assign flags_o = flag_q;
endmodule

// File: rtl/bl_checker.sv
module bl_checker
  import bytelane_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic [2:0]              op_i,
  input logic [LANES*LANE_W-1:0] a_i,
  input logic [LANES*LANE_W-1:0] b_i,
  input logic [LANES*LANE_W-1:0] res_o,
  input logic [LANES-1:0]        flags_o
);
  localparam int SAD_W = $clog2(LANES * ((1 << LANE_W) - 1) + 1);

  logic seen_clk = 1'b0;
  logic rst_d    = 1'b0;
  always @(posedge clk) begin
    if (seen_clk && rst_d) begin
      p_reset_clear_r10: assert (res_o == '0 && flags_o == '0)
        else $error("reset did not clear outputs");
    end
    seen_clk <= 1'b1;
    rst_d    <= rst;
  end

  p_flag_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_HADD || op_i == OP_QADD || op_i == OP_SEL || op_i == OP_SAD)
      |=> $stable(flags_o));

  p_unused_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_RSV6 || op_i == OP_RSV7) |=> (res_o == '0 && $stable(flags_o)));

  p_sad_width_r7: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SAD) |=> ((res_o >> SAD_W) == '0));

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    p_sub_flag_r3: assert property (@(posedge clk) disable iff (rst)
      (op_i == OP_SUB) |=> flags_o[g] ==
        ($past(a_i[g*LANE_W +: LANE_W]) >= $past(b_i[g*LANE_W +: LANE_W])));

    p_qadd_floor_r5: assert property (@(posedge clk) disable iff (rst)
      (op_i == OP_QADD) |=>
        (res_o[g*LANE_W +: LANE_W] >= $past(a_i[g*LANE_W +: LANE_W]) &&
         res_o[g*LANE_W +: LANE_W] >= $past(b_i[g*LANE_W +: LANE_W])));

    p_hadd_range_r4: assert property (@(posedge clk) disable iff (rst)
      (op_i == OP_HADD) |=>
        ((res_o[g*LANE_W +: LANE_W] >= $past(a_i[g*LANE_W +: LANE_W]) ||
          res_o[g*LANE_W +: LANE_W] >= $past(b_i[g*LANE_W +: LANE_W])) &&
         (res_o[g*LANE_W +: LANE_W] <= $past(a_i[g*LANE_W +: LANE_W]) ||
          res_o[g*LANE_W +: LANE_W] <= $past(b_i[g*LANE_W +: LANE_W]))));

    p_sel_pick_r6: assert property (@(posedge clk) disable iff (rst)
      (op_i == OP_SEL) |=> res_o[g*LANE_W +: LANE_W] ==
        ($past(flags_o[g]) ? $past(a_i[g*LANE_W +: LANE_W])
                           : $past(b_i[g*LANE_W +: LANE_W])));
  end
endmodule

bind bytelane_alu bl_checker #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .op_i    (op_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .res_o   (res_o),
  .flags_o (flags_o)
);

// File: tb/sim_bytelane_alu.sv
module sim_bytelane_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_i = 3'd0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [31:0] res_o;
  logic [3:0]  flags_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [3:0] m_flags = 4'h0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  bytelane_alu u0 (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .res_o(res_o), .flags_o(flags_o)
  );

  function automatic logic [31:0] exp_res(input logic [2:0] op,
      input logic [31:0] a, input logic [31:0] b, input logic [3:0] f);
    logic [31:0] r = '0;
    int s = 0;
    for (int i = 0; i < 4; i++) begin
      int x = int'(a[i*8 +: 8]);
      int y = int'(b[i*8 +: 8]);
      int v = 0;
      case (op)
        3'd0: v = (x + y) % 256;
        3'd1: v = (x - y + 256) % 256;
        3'd2: v = (x + y) / 2;
        3'd3: v = (x + y > 255) ? 255 : x + y;
        3'd4: v = f[i] ? x : y;
        default: v = 0;
      endcase
      r[i*8 +: 8] = 8'(v);
      s += (x >= y) ? x - y : y - x;
    end
    if (op == 3'd5) r = 32'(s);
    return r;
  endfunction

  function automatic logic [3:0] exp_flags(input logic [2:0] op,
      input logic [31:0] a, input logic [31:0] b, input logic [3:0] f);
    logic [3:0] n = f;
    for (int i = 0; i < 4; i++) begin
      int x = int'(a[i*8 +: 8]);
      int y = int'(b[i*8 +: 8]);
      if (op == 3'd0) n[i] = (x + y > 255);
      if (op == 3'd1) n[i] = (x >= y);
    end
    return n;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // Issue one operation; result and flags are checked one edge later (R12).
  task automatic run_op(input string req, input logic [2:0] op,
      input logic [31:0] a, input logic [31:0] b, output logic [31:0] got);
    logic [31:0] er;
    logic [3:0]  ef;
    @(negedge clk);
    op_i = op; a_i = a; b_i = b;
    er = exp_res(op, a, b, m_flags);
    ef = exp_flags(op, a, b, m_flags);
    @(posedge clk);
    #1;
    m_flags = ef;
    got = res_o;
    chk({req, " result"}, res_o, er);
    chk({req, " flags"}, {28'd0, flags_o}, {28'd0, ef});
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; op_i = 3'd0; a_i = 32'hFFFF_FFFF; b_i = 32'h0101_0101;
    repeat (2) @(posedge clk);
    #1;
    chk("R10 result in reset", res_o, 32'h0);
    chk("R10 flags in reset", {28'd0, flags_o}, 32'h0);
    m_flags = 4'h0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_add();
    logic [31:0] r;
    run_op("R1 R2 add literal", 3'd0, 32'h01FF_7F10, 32'h0101_8010, r);
    chk("R1 add literal value", r, 32'h0200_FF20);
    chk("R2 add literal carry", {28'd0, flags_o}, 32'h4);
    run_op("R1 R2 add all carry", 3'd0, 32'h8080_8080, 32'h80FF_8081, r);
    run_op("R1 R2 add zero", 3'd0, 32'h0, 32'h0, r);
  endtask

  task automatic t_sub();
    logic [31:0] r;
    run_op("R3 sub literal", 3'd1, 32'h0510_00FF, 32'h0520_0100, r);
    chk("R3 sub literal value", r, 32'h00F0_FFFF);
    chk("R3 sub literal ge", {28'd0, flags_o}, 32'h9);
    run_op("R3 sub mixed", 3'd1, 32'h7F00_FF01, 32'h8000_FE02, r);
  endtask

  task automatic t_hadd_qadd();
    logic [31:0] r;
    run_op("R4 hadd", 3'd2, 32'hFF01_8064, 32'hFF00_7F65, r);
    chk("R4 hadd no overflow", r, 32'hFF00_7F64);
    run_op("R5 qadd", 3'd3, 32'hFF80_7F10, 32'h0180_8020, r);
    chk("R5 qadd clamp", r, 32'hFFFF_FF30);
  endtask

  task automatic t_sel();
    logic [31:0] r;
    run_op("R6 set flags", 3'd1, 32'h0100_0100, 32'h0001_0001, r);
    run_op("R6 select", 3'd4, 32'hAAAA_AAAA, 32'h5555_5555, r);
    chk("R6 select by flags 1010", r, 32'hAA55_AA55);
  endtask

  task automatic t_sad();
    logic [31:0] r;
    run_op("R7 sad max", 3'd5, 32'hFF00_FF00, 32'h00FF_00FF, r);
    chk("R7 sad 1020", r, 32'd1020);
    run_op("R7 sad mixed", 3'd5, 32'h1020_3040, 32'h2010_4030, r);
    chk("R7 sad 64", r, 32'd64);
  endtask

  task automatic t_hold();
    logic [31:0] r;
    run_op("R8 set flags", 3'd1, 32'h0A00_0A00, 32'h0005_0005, r);
    run_op("R8 hadd hold", 3'd2, 32'h1234_5678, 32'h9ABC_DEF0, r);
    run_op("R8 qadd hold", 3'd3, 32'hFFFF_FFFF, 32'h0101_0101, r);
    run_op("R8 sel hold", 3'd4, 32'h1111_1111, 32'h2222_2222, r);
    run_op("R8 sad hold", 3'd5, 32'h0000_0000, 32'hFFFF_FFFF, r);
    chk("R8 flags after four ops", {28'd0, flags_o}, 32'hA);
    run_op("R9 op6", 3'd6, 32'hFFFF_FFFF, 32'h0101_0101, r);
    run_op("R9 op7", 3'd7, 32'h1234_5678, 32'h1111_1111, r);
    chk("R9 op7 zero", r, 32'h0);
    chk("R9 flags kept", {28'd0, flags_o}, 32'hA);
  endtask

  task automatic t_absdiff();
    logic [31:0] d1, d2, r;
    run_op("R11 sub a,b", 3'd1, 32'h10FF_0080, 32'h2000_007F, d1);
    run_op("R11 sub b,a", 3'd1, 32'h2000_007F, 32'h10FF_0080, d2);
    run_op("R11 select", 3'd4, d2, d1, r);
    chk("R11 absolute difference", r, 32'h10FF_0001);
  endtask

  task automatic t_mid_reset();
    logic [31:0] r;
    run_op("R10 pre", 3'd0, 32'hFFFF_FFFF, 32'h0101_0101, r);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R10 mid-run result", res_o, 32'h0);
    chk("R10 mid-run flags", {28'd0, flags_o}, 32'h0);
    m_flags = 4'h0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_hadd_qadd();
    t_sel();
    t_sad();
    t_hold();
    t_absdiff();
    t_mid_reset();
    finished = 1'b1;
    summary();
  end
endmodule